// File: doc/BRIEF.md
# Closed-Page DRAM Command Sequencer

This block sits between a simple request port and a DRAM command interface. A host offers one read or write at a time, each tagged with a device select, a bank, a row and a column. The block turns every accepted request into a fixed three-command sequence. First it opens the row, then it performs the column read or write, and then it closes the row again. No row is left open between requests. The gaps between commands come from four cycle-count parameters, and each gap is timed by one down-counter that is reloaded at every phase change.

Row and column addresses go out on one shared address bus, on different cycles. Data has a bus of its own. Write data is driven outward with an output enable, and read data comes back inward on the same pins. Read data is captured a fixed latency after the read command and is handed to the host with a one-cycle valid pulse. The request port accepts a new request only once the closing gap of the previous access has run out. A request that is waiting at that moment opens its row on the very first legal cycle.

Top module: `cpage_seq`

## Requirements
- R1: After reset the command bus carries NOP (code 0), `req_ready` is 1, `dq_oe` is 0 and `rd_valid` is 0.
- R2: Command codes are NOP=0, ACTIVATE=1, READ=2, WRITE=3, PRECHARGE=4. An accepted read produces exactly ACTIVATE, READ, PRECHARGE, and an accepted write produces exactly ACTIVATE, WRITE, PRECHARGE. The ACTIVATE is issued in the cycle right after acceptance, and every other cycle carries NOP.
- R3: The READ or WRITE command is issued exactly `T_RCD` cycles after its ACTIVATE.
- R4: ACTIVATE and PRECHARGE put the row on `cmd_addr`. READ and WRITE put the column there, zero-extended. All three commands carry the request's device and bank on `cmd_dev` and `cmd_bank`.
- R5: `dq_in` is sampled in the cycle `T_CL` cycles after READ. `rd_valid` pulses for one cycle, `T_CL`+1 cycles after READ, with that sample on `rd_data`.
- R6: `dq_oe` is 1 only in the WRITE cycle, and in that cycle `dq_out` equals the request's write data. PRECHARGE follows WRITE after exactly `T_WR` cycles.
- R7: For a read, PRECHARGE follows READ after exactly `T_CL` cycles, and `dq_oe` stays 0 throughout the read.
- R8: `req_ready` is 0 from the cycle after acceptance until `T_RP`-1 cycles after PRECHARGE, when it returns to 1. The next ACTIVATE therefore comes no earlier than `T_RP` cycles after PRECHARGE, and comes exactly then when a request is already waiting.
- R9: While `req_ready` is 0, `req_valid` and the request fields have no effect on the commands issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | DEV_W | Device select |
| req_bank | input | BANK_W | Bank |
| req_row | input | ROW_W | Row |
| req_col | input | COL_W | Column |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | DATA_W | Read data |
| cmd | output | 3 | Command code |
| cmd_dev | output | DEV_W | Device field of command |
| cmd_bank | output | BANK_W | Bank field of command |
| cmd_addr | output | ADDR_W | Shared row/column address |
| dq_out | output | DATA_W | Data driven to memory |
| dq_oe | output | 1 | Data output enable |
| dq_in | input | DATA_W | Data returned from memory |

## Verification
The bench goes after the boundaries of each timing window. If the READ or WRITE lands one cycle early or late, the gap check against the ACTIVATE reports it. If the capture point is off by one, the wrong sample or nothing is returned, because the bench drives the read word for a single cycle. It also holds a request waiting across the end of the closing gap. A ready that rises late adds a dead cycle before the next ACTIVATE, and one that rises early starts it inside the precharge window. It keeps `req_valid` high with changed fields while the block is busy. A design that listened then would emit commands the scoreboard never queued, or would carry a wrong row into PRECHARGE.

// File: rtl/cpage_pkg.sv
package cpage_pkg;
    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } cmd_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RCD  = 2'd1,
        PH_COL  = 2'd2,
        PH_RP   = 2'd3
    } phase_e;
endpackage

// File: rtl/cpage_gap_sel.sv
module cpage_gap_sel
    import cpage_pkg::*;
#(
    parameter int T_RCD = 3,
    parameter int T_CL  = 4,
    parameter int T_WR  = 2,
    parameter int T_RP  = 3,
    parameter int CNT_W = 3
) (
    input  phase_e             tgt_ph,
    input  logic               is_wr,
    output logic [CNT_W-1:0]   load
);
    // Reload value is the gap minus one: the counter reaches zero in the
    // cycle before the next command is issued.
    always_comb begin
        case (tgt_ph)
            PH_RCD:  load = CNT_W'(T_RCD - 1);
            PH_COL:  load = is_wr ? CNT_W'(T_WR - 1) : CNT_W'(T_CL - 1);
            PH_RP:   load = CNT_W'(T_RP - 1);
            default: load = '0;
        endcase
    end
endmodule

// File: rtl/cpage_addr_mux.sv
module cpage_addr_mux #(
    parameter int ROW_W  = 12,
    parameter int COL_W  = 8,
    parameter int ADDR_W = 12
) (
    input  logic              use_col,
    input  logic [ROW_W-1:0]  row,
    input  logic [COL_W-1:0]  col,
    output logic [ADDR_W-1:0] addr
);
    assign addr = use_col ? ADDR_W'(col) : ADDR_W'(row);
endmodule

// File: rtl/cpage_seq.sv
module cpage_seq
    import cpage_pkg::*;
#(
    parameter int DEV_W  = 1,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12,
    parameter int COL_W  = 8,
    parameter int DATA_W = 16,
    parameter int T_RCD  = 3,
    parameter int T_CL   = 4,
    parameter int T_WR   = 2,
    parameter int T_RP   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [2:0]        cmd,
    output logic [DEV_W-1:0]  cmd_dev,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] cmd_addr,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    input  logic [DATA_W-1:0] dq_in
);
    localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int G1     = (T_RCD > T_CL) ? T_RCD : T_CL;
    localparam int G2     = (T_WR > T_RP) ? T_WR : T_RP;
    localparam int MAXG   = (G1 > G2) ? G1 : G2;
    localparam int CNT_W  = (MAXG < 2) ? 1 : $clog2(MAXG);

    typedef struct packed {
        phase_e             ph;
        logic [CNT_W-1:0]   cnt;
        logic               wr;
        logic [DEV_W-1:0]   dev;
        logic [BANK_W-1:0]  bank;
        logic [ROW_W-1:0]   row;
        logic [COL_W-1:0]   col;
        logic [DATA_W-1:0]  wdat;
        cmd_e               cmd;
        logic [ADDR_W-1:0]  addr;
        logic               oe;
        logic [DATA_W-1:0]  dq;
        logic               cap;
        logic               rv;
        logic [DATA_W-1:0]  rdat;
    } seq_t;

    seq_t s_q, s_d;

    phase_e            tgt_ph;
    logic [CNT_W-1:0]  gap_load;
    logic [ADDR_W-1:0] mux_addr;
    logic [ROW_W-1:0]  mux_row;
    logic              ready;
    logic              accept;

    // Phase whose gap gets loaded on leaving the current phase
    always_comb begin
        case (s_q.ph)
            PH_RCD:  tgt_ph = PH_COL;
            PH_COL:  tgt_ph = PH_RP;
            default: tgt_ph = PH_RCD;
        endcase
    end

    cpage_gap_sel #(
        .T_RCD (T_RCD),
        .T_CL  (T_CL),
        .T_WR  (T_WR),
        .T_RP  (T_RP),
        .CNT_W (CNT_W)
    ) u_gap (
        .tgt_ph (tgt_ph),
        .is_wr  (s_q.wr),
        .load   (gap_load)
    );

    assign ready   = (s_q.ph == PH_IDLE) || ((s_q.ph == PH_RP) && (s_q.cnt == '0));
    assign accept  = req_valid && ready;
    assign mux_row = ready ? req_row : s_q.row;

    cpage_addr_mux #(
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .ADDR_W (ADDR_W)
    ) u_amux (
        .use_col (s_q.ph == PH_RCD),
        .row     (mux_row),
        .col     (s_q.col),
        .addr    (mux_addr)
    );

    always_comb begin
        s_d      = s_q;
        s_d.cmd  = CMD_NOP;
        s_d.oe   = 1'b0;
        s_d.cap  = 1'b0;
        s_d.rv   = s_q.cap;
        if (s_q.cap) begin
            s_d.rdat = dq_in;
        end

        case (s_q.ph)
            PH_RCD: begin
                if (s_q.cnt == '0) begin
                    s_d.cmd  = s_q.wr ? CMD_WR : CMD_RD;
                    s_d.addr = mux_addr;
                    s_d.ph   = PH_COL;
                    s_d.cnt  = gap_load;
                    s_d.oe   = s_q.wr;
                    s_d.dq   = s_q.wdat;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_COL: begin
                if (s_q.cnt == '0) begin
                    s_d.cmd  = CMD_PRE;
                    s_d.addr = mux_addr;
                    s_d.ph   = PH_RP;
                    s_d.cnt  = gap_load;
                    s_d.cap  = !s_q.wr;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_RP: begin
                if (s_q.cnt == '0) begin
                    s_d.ph = PH_IDLE;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: ;
        endcase

        if (accept) begin
            s_d.wr   = req_write;
            s_d.dev  = req_dev;
            s_d.bank = req_bank;
            s_d.row  = req_row;
            s_d.col  = req_col;
            s_d.wdat = req_wdata;
            s_d.cmd  = CMD_ACT;
            s_d.addr = mux_addr;
            s_d.ph   = PH_RCD;
            s_d.cnt  = gap_load;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready = ready;
    assign rd_valid  = s_q.rv;
    assign rd_data   = s_q.rdat;
    assign cmd       = s_q.cmd;
    assign cmd_dev   = s_q.dev;
    assign cmd_bank  = s_q.bank;
    assign cmd_addr  = s_q.addr;
    assign dq_out    = s_q.dq;
    assign dq_oe     = s_q.oe;
endmodule

// File: rtl/cpage_seq_chk.sv
module cpage_seq_chk #(
    parameter int T_RCD = 3,
    parameter int T_CL  = 4,
    parameter int T_RP  = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [2:0] cmd,
    input logic       dq_oe,
    input logic       rd_valid
);
    logic [15:0] since_act, since_rd, since_pre;
    logic        pre_seen;

    function automatic logic [15:0] bump(input logic hit, input logic [15:0] v);
        if (hit)                return 16'd1;
        else if (v == 16'd0)    return 16'd0;
        else if (v == 16'hFFFF) return v;
        else                    return v + 16'd1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_act <= '0;
            since_rd  <= '0;
            since_pre <= '0;
            pre_seen  <= 1'b0;
        end else begin
            since_act <= bump(cmd == 3'd1, since_act);
            since_rd  <= bump(cmd == 3'd2, since_rd);
            since_pre <= bump(cmd == 3'd4, since_pre);
            if (cmd == 3'd4) pre_seen <= 1'b1;
        end
    end

    // R2
    act_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (cmd == 3'd1));
    // R3
    rcd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd == 3'd2) || (cmd == 3'd3)) |-> (since_act == 16'(T_RCD)));
    // R5
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (since_rd == 16'(T_CL + 1)));
    // R6
    oe_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (cmd == 3'd3));
    // R8
    rp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd == 3'd1) && pre_seen) |-> (since_pre >= 16'(T_RP)));
    // R8
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd1) |-> !req_ready);
endmodule

bind cpage_seq cpage_seq_chk #(
    .T_RCD (T_RCD),
    .T_CL  (T_CL),
    .T_RP  (T_RP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .cmd       (cmd),
    .dq_oe     (dq_oe),
    .rd_valid  (rd_valid)
);

// File: tb/cpage_seq_bench.sv
`timescale 1ns/1ps
module cpage_seq_bench;
    localparam int T_RCD = 3;
    localparam int T_CL  = 4;
    localparam int T_WR  = 2;
    localparam int T_RP  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_dev = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [11:0] req_row = '0;
    logic [7:0]  req_col = '0;
    logic [15:0] req_wdata = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic [2:0]  cmd;
    logic        cmd_dev;
    logic [1:0]  cmd_bank;
    logic [11:0] cmd_addr;
    logic [15:0] dq_out;
    logic        dq_oe;
    logic [15:0] dq_in = '0;

    always #2.5 clk = ~clk;

    cpage_seq #(
        .DEV_W(1), .BANK_W(2), .ROW_W(12), .COL_W(8), .DATA_W(16),
        .T_RCD(T_RCD), .T_CL(T_CL), .T_WR(T_WR), .T_RP(T_RP)
    ) u_cpage_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_dev(req_dev), .req_bank(req_bank), .req_row(req_row),
        .req_col(req_col), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .cmd(cmd), .cmd_dev(cmd_dev), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
        .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
    );

    typedef struct {
        logic [2:0]  c;
        logic        dev;
        logic [1:0]  bank;
        logic [11:0] addr;
        int          gap;
        bit          exact;
        logic [15:0] wd;
        string       tag;
    } exp_t;

    exp_t        expq[$];
    logic [15:0] rdq[$];

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    function automatic logic [15:0] pat(input logic [7:0] c, input logic [1:0] b, input logic d);
        return {c ^ 8'h3C, 5'b10101, d, b};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Driver: offers a request, pushes expected items on acceptance.
    task automatic do_req(input bit wr, input logic dev, input logic [1:0] bank,
                          input logic [11:0] row, input logic [7:0] col,
                          input logic [15:0] wd, input int linger);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_dev = dev; req_bank = bank;
        req_row = row; req_col = col; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        e = '{3'd1, dev, bank, row, T_RP, 1'b0, 16'h0, "R8 activate"};
        expq.push_back(e);
        e = '{wr ? 3'd3 : 3'd2, dev, bank, {4'h0, col}, T_RCD, 1'b1, wd, "R3 column"};
        expq.push_back(e);
        e = '{3'd4, dev, bank, row, wr ? T_WR : T_CL, 1'b1, 16'h0, wr ? "R6 precharge" : "R7 precharge"};
        expq.push_back(e);
        if (!wr) rdq.push_back(pat(col, bank, dev));
        @(posedge clk);
        #1;
        if (linger > 0) begin
            // R9: junk request held while busy
            req_write = ~wr; req_row = ~row; req_col = ~col; req_bank = ~bank; req_dev = ~dev;
            repeat (linger) @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    // Monitor / scoreboard
    int          last_cmd_cyc = -1;
    int          last_rd_cyc = -1000;
    int          pre_cyc = -1000;
    int          acc_cyc = -1000;
    int          rd_due = 0;
    logic [7:0]  rd_col;
    logic [1:0]  rd_bank;
    logic        rd_dev;

    always @(negedge clk) begin
        if (rst_n) begin
            exp_t e;
            logic [15:0] wd_exp;
            wd_exp = '0;
            dq_in = '0;
            if (rd_due > 0) begin
                rd_due--;
                if (rd_due == 0) dq_in = pat(rd_col, rd_bank, rd_dev);
            end
            if (cyc == acc_cyc + 1) begin
                check(cmd == 3'd1, "R2 activate after accept", 32'(cmd), 32'd1);
                check(req_ready == 1'b0, "R8 ready low after accept", 32'(req_ready), 32'd0);
            end
            if (cmd != 3'd0) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R9 unexpected command", 32'(cmd), 32'd0);
                end else begin
                    int g;
                    bit gap_ok;
                    e = expq.pop_front();
                    g = cyc - last_cmd_cyc;
                    gap_ok = (last_cmd_cyc < 0) || (e.exact ? (g == e.gap) : (g >= e.gap));
                    check(cmd == e.c, {e.tag, " R2 code"}, 32'(cmd), 32'(e.c));
                    check(cmd_addr == e.addr && cmd_dev == e.dev && cmd_bank == e.bank,
                          {e.tag, " R4 fields"}, {cmd_dev, cmd_bank, 4'h0, cmd_addr},
                          {e.dev, e.bank, 4'h0, e.addr});
                    check(gap_ok, {e.tag, " gap"}, 32'(g), 32'(e.gap));
                    wd_exp = e.wd;
                end
                last_cmd_cyc = cyc;
                if (cmd == 3'd2) begin
                    rd_due = T_CL; rd_col = cmd_addr[7:0]; rd_bank = cmd_bank; rd_dev = cmd_dev;
                    last_rd_cyc = cyc;
                end
                if (cmd == 3'd4) pre_cyc = cyc;
            end
            if (dq_oe || cmd == 3'd3) begin
                check(dq_oe && cmd == 3'd3 && dq_out == wd_exp, "R6 write data enable",
                      {dq_oe, 12'h0, cmd, dq_out}, {1'b1, 12'h0, 3'd3, wd_exp});
            end
            if (rd_due > 0 || (cyc - last_rd_cyc) <= T_CL) begin
                if (dq_oe) check(1'b0, "R7 enable during read window", 32'(dq_oe), 32'd0);
            end
            if (cyc == pre_cyc + T_RP - 1)
                check(req_ready == 1'b1, "R8 ready returns", 32'(req_ready), 32'd1);
            if (T_RP >= 2 && cyc == pre_cyc + T_RP - 2 && cyc > pre_cyc)
                check(req_ready == 1'b0, "R8 ready still low", 32'(req_ready), 32'd0);
            if (rd_valid) begin
                logic [15:0] x;
                x = (rdq.size() > 0) ? rdq.pop_front() : 16'hxxxx;
                check(rd_data === x, "R5 read data", 32'(rd_data), 32'(x));
                check(cyc == last_rd_cyc + T_CL + 1, "R5 read latency",
                      32'(cyc - last_rd_cyc), 32'(T_CL + 1));
            end
            if (req_valid && req_ready) acc_cyc = cyc;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(cmd == 3'd0, "R1 reset cmd", 32'(cmd), 32'd0);
        check(req_ready == 1'b1, "R1 reset ready", 32'(req_ready), 32'd1);
        check(dq_oe == 1'b0, "R1 reset oe", 32'(dq_oe), 32'd0);
        check(rd_valid == 1'b0, "R1 reset rd_valid", 32'(rd_valid), 32'd0);
        repeat (3) @(negedge clk);
        check(cmd == 3'd0, "R2 idle NOP", 32'(cmd), 32'd0);

        do_req(1'b1, 1'b0, 2'd1, 12'h123, 8'h45, 16'hBEEF, 0);
        do_req(1'b0, 1'b0, 2'd1, 12'h123, 8'h45, 16'h0000, 0);
        do_req(1'b0, 1'b1, 2'd3, 12'hFFF, 8'hFF, 16'h0000, 3);
        do_req(1'b1, 1'b1, 2'd2, 12'h000, 8'h00, 16'h0001, 0);
        repeat (10) @(negedge clk);
        do_req(1'b0, 1'b0, 2'd0, 12'h800, 8'h80, 16'h0000, 0);
        do_req(1'b1, 1'b0, 2'd3, 12'h7A5, 8'h01, 16'h5A5A, 0);
        repeat (30) @(negedge clk);

        check(expq.size() == 0, "R9 commands all seen", 32'(expq.size()), 32'd0);
        check(rdq.size() == 0, "R5 reads all returned", 32'(rdq.size()), 32'd0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule